// File: doc/BRIEF.md
# Transmit Buffer Low-Level Request Logic

This block holds the words a host has queued for a serial transmitter and decides when the host should supply more. Words enter through a push port and leave in order through a pop port toward the serializer. An occupancy counter tracks how many words are held. A programmable low-level mark is compared with it, and the result drives a "room available" flag.

The flag is routed to exactly one request output. When DMA select is on it becomes a DMA request. Otherwise it becomes an interrupt, provided the interrupt enable is set. The mark can be written only while the transmitter is disabled. The mark and the occupancy count can both be read at any time through a small register port.

The flag has hysteresis driven by data movement. A push that lifts occupancy above the mark clears it. A pop that brings occupancy to the mark or below sets it. Rewriting the mark leaves the flag as it is. The mark must be programmed below the buffer depth.

Top module: `txq_lowmark`

## Requirements
- R1: After reset the mark reads 0, the count reads 0, the overflow bit is 0 and the flag is set, so irq_req is 1 when irq_en=1 and dma_sel=0.
- R2: reg_rdata shows the mark when reg_sel=0 and the occupancy count, zero-extended to 8 bits, when reg_sel=1, combinationally and at any time.
- R3: A write with reg_wr=1, reg_sel=0 and tx_en=0 loads reg_wdata into the mark at the next clock edge; the same write with tx_en=1 is ignored and the mark keeps its old value.
- R4: A push that is not paired with a pop and leaves the occupancy above the mark clears the flag.
- R5: A pop that is not paired with a push and leaves the occupancy at or below the mark sets the flag.
- R6: Writing the mark neither clears nor sets the flag; only data movement changes it.
- R7: dma_req equals flag AND dma_sel; irq_req equals flag AND irq_en AND NOT dma_sel; the two are never high together.
- R8: A push while the buffer holds DEPTH words and no pop is accepted is dropped, leaves the stored words intact and sets a sticky overflow bit that only reset clears.
- R9: A push and a pop accepted in the same cycle leave the count unchanged and both move data. This also holds when the buffer is full, and in that case no overflow is raised.
- R10: pop_data shows the oldest stored word and pop_valid is high whenever the count is non-zero; a pop while empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects the mark, 1 selects the count |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| push_valid | input | 1 | Host word offered |
| push_data | input | DW | Host word |
| pop_req | input | 1 | Serializer takes the head word |
| pop_data | output | DW | Head word |
| pop_valid | output | 1 | Buffer not empty |
| tx_en | input | 1 | Transmitter enable; blocks mark writes |
| irq_en | input | 1 | Interrupt enable |
| dma_sel | input | 1 | Route the flag to the DMA request |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| overflow | output | 1 | Sticky dropped-push indicator |

## Verification
A push and a pop can land in the same cycle. The bench forces this both at mid occupancy and with the buffer full. It judges the outcome by three things: the count stays the same, the next head word is the one the bench expects, and no overflow appears. A mark write can also coincide with a set flag whose occupancy already sits above the new mark. The bench provokes this by lowering and raising the mark at a fixed occupancy, then confirms that only the following push or pop moves the flag. Every mark from 0 to DEPTH-1 is swept through a full fill and drain, and the expected count, flag and data are computed arithmetically.

// File: rtl/txq_lowmark.sv
module txq_lowmark #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int RW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  output logic          pop_valid,
  input  logic          tx_en,
  input  logic          irq_en,
  input  logic          dma_sel,
  output logic          irq_req,
  output logic          dma_req,
  output logic          overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [RW-1:0] thr;
  logic          flag, ovf;

  wire full      = (cnt == CW'(DEPTH));
  wire pop_fire  = pop_req && (cnt != '0);
  wire push_fire = push_valid && (!full || pop_fire);
  wire push_drop = push_valid && !push_fire;
  wire thr_we    = reg_wr && !reg_sel && !tx_en;
  wire [CW-1:0] cnt_nx = cnt + CW'(push_fire) - CW'(pop_fire);
  wire at_or_below = int'(cnt_nx) <= int'(thr);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (push_fire) mem[wp] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      thr  <= '0;
      flag <= 1'b1;
      ovf  <= 1'b0;
    end else begin
      if (push_fire) wp <= bump(wp);
      if (pop_fire)  rp <= bump(rp);
      cnt <= cnt_nx;
      if (thr_we)    thr <= reg_wdata;
      if (push_drop) ovf <= 1'b1;
      if (pop_fire && !push_fire && at_or_below)      flag <= 1'b1;
      else if (push_fire && !pop_fire && !at_or_below) flag <= 1'b0;
    end
  end

  assign reg_rdata = reg_sel ? RW'(cnt) : thr;
  assign pop_data  = mem[rp];
  assign pop_valid = (cnt != '0);
  assign dma_req   = flag && dma_sel;
  assign irq_req   = flag && irq_en && !dma_sel;
  assign overflow  = ovf;
endmodule

module txq_lowmark_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4,
  parameter int RW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_sel,
  input logic          reg_wr,
  input logic          tx_en,
  input logic          push_valid,
  input logic          pop_req,
  input logic [CW-1:0] cnt,
  input logic [RW-1:0] thr,
  input logic          flag,
  input logic          irq_req,
  input logic          dma_req,
  input logic          overflow
);
  wire pf = pop_req && (cnt != '0);
  wire uf = push_valid && ((cnt != CW'(DEPTH)) || pf);

  a_r3_locked_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && tx_en) |=> $stable(thr));
  a_r5_pop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (pf && !uf && (int'(cnt) - 1 <= int'(thr))) |=> flag);
  a_r4_push_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !pf && (int'(cnt) + 1 > int'(thr))) |=> !flag);
  a_r6_idle_flag_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!uf && !pf) |=> $stable(flag));
  a_r7_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_req && dma_req));
  a_r8_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r9_paired_count: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && pf) |=> $stable(cnt));
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);
endmodule

bind txq_lowmark txq_lowmark_chk #(.DEPTH(DEPTH), .CW(CW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .tx_en(tx_en),
  .push_valid(push_valid), .pop_req(pop_req), .cnt(cnt), .thr(thr), .flag(flag),
  .irq_req(irq_req), .dma_req(dma_req), .overflow(overflow)
);

// File: tb/tb_txq_lowmark.sv
module tb_txq_lowmark;
  localparam int DEPTH = 8;
  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_wr = 0, push_valid = 0, pop_req = 0;
  logic tx_en = 0, irq_en = 1, dma_sel = 0;
  logic [7:0] reg_wdata = 0, push_data = 0;
  logic [7:0] reg_rdata, pop_data;
  logic pop_valid, irq_req, dma_req, overflow;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  txq_lowmark #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push_valid(push_valid),
    .push_data(push_data), .pop_req(pop_req), .pop_data(pop_data),
    .pop_valid(pop_valid), .tx_en(tx_en), .irq_en(irq_en), .dma_sel(dma_sel),
    .irq_req(irq_req), .dma_req(dma_req), .overflow(overflow));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic do_reset(); rst_n = 0; tick(); rst_n = 1; tick(); endtask
  task automatic wr_thr(input int v); reg_wr = 1; reg_sel = 0; reg_wdata = 8'(v); tick(); reg_wr = 0; endtask
  task automatic push(input int d); push_valid = 1; push_data = 8'(d); tick(); push_valid = 0; endtask
  task automatic pop(); pop_req = 1; tick(); pop_req = 0; endtask
  task automatic rd(input logic s, output int v); reg_sel = s; #1; v = int'(reg_rdata); endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v;
    do_reset();
    rd(0, v); chk("R1 mark", v, 0);
    rd(1, v); chk("R1 count", v, 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 irq", int'(irq_req), 1);
    pop();
    rd(1, v); chk("R10 empty pop count", v, 0);
    chk("R10 empty pop flag", int'(irq_req), 1);

    for (int t = 0; t < DEPTH; t++) begin
      do_reset();
      wr_thr(t);
      rd(0, v); chk("R3 mark write", v, t);
      for (int k = 1; k <= DEPTH; k++) begin
        push(t * 16 + k);
        rd(1, v); chk("R2 count fill", v, k);
        chk("R4 flag fill", int'(irq_req), int'(k <= t));
        chk("R10 valid", int'(pop_valid), 1);
      end
      chk("R8 no overflow yet", int'(overflow), 0);
      push(255);
      rd(1, v); chk("R8 full count", v, DEPTH);
      chk("R8 overflow", int'(overflow), 1);
      for (int k = 1; k <= DEPTH; k++) begin
        chk("R10 order", int'(pop_data), (t * 16 + k) & 255);
        pop();
        rd(1, v); chk("R2 count drain", v, DEPTH - k);
        chk("R5 flag drain", int'(irq_req), int'(DEPTH - k <= t));
      end
      chk("R8 sticky", int'(overflow), 1);
      chk("R10 empty valid", int'(pop_valid), 0);
    end

    do_reset();
    wr_thr(5);
    tx_en = 1; wr_thr(2); tx_en = 0;
    rd(0, v); chk("R3 locked write", v, 5);
    for (int k = 1; k <= 3; k++) push(k);
    chk("R6 flag before", int'(irq_req), 1);
    wr_thr(1);
    chk("R6 lower keeps flag", int'(irq_req), 1);
    push(4);
    chk("R4 push clears", int'(irq_req), 0);
    wr_thr(6);
    chk("R6 raise keeps clear", int'(irq_req), 0);
    for (int c = 0; c < 4; c++) begin
      irq_en = c[0]; dma_sel = c[1]; #1;
      chk("R7 irq low flag", int'(irq_req), 0);
      chk("R7 dma low flag", int'(dma_req), 0);
    end
    pop();
    for (int c = 0; c < 4; c++) begin
      irq_en = c[0]; dma_sel = c[1]; #1;
      chk("R7 irq", int'(irq_req), int'(c[0] && !c[1]));
      chk("R7 dma", int'(dma_req), int'(c[1]));
    end
    irq_en = 1; dma_sel = 0;

    chk("R9 head before", int'(pop_data), 2);
    push_valid = 1; push_data = 8'd50; pop_req = 1; tick(); push_valid = 0; pop_req = 0;
    rd(1, v); chk("R9 count kept", v, 3);
    chk("R9 head after", int'(pop_data), 3);

    do_reset();
    for (int k = 1; k <= DEPTH; k++) push(k + 100);
    push_valid = 1; push_data = 8'd200; pop_req = 1; tick(); push_valid = 0; pop_req = 0;
    rd(1, v); chk("R9 full count", v, DEPTH);
    chk("R9 full no overflow", int'(overflow), 0);
    for (int k = 2; k <= DEPTH; k++) begin
      chk("R9 full order", int'(pop_data), k + 100);
      pop();
    end
    chk("R9 paired word", int'(pop_data), 200);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule